// File: doc/BRIEF.md
# Cartridge-Bus DMA Engine

This block copies byte streams between a main-memory port and a cartridge address space. Software programs a main-memory address and a cartridge address, then writes one of two length registers; the register it writes sets the direction and starts the copy. The cartridge address picks the target device. One range maps to a small save memory, which can be read or written. Another range maps to a read-only ROM, which can only be copied into main memory.

Every byte index is XOR-ed with 3 on both sides, so the bytes inside each 32-bit word come out in reverse order. A ROM copy that runs past the end of the ROM is padded with zeros. The first successful ROM copy after reset also writes the main-memory size into a fixed boot word. A busy flag covers the whole transfer. Every completion raises an interrupt flag, which stays set until software acknowledges it.

Top module: `cart_dma`

## Requirements
- R1: `reg_sel` codes are 0 for the main-memory address, 1 for the cartridge address, 2 for the memory-to-cartridge length and 3 for the cartridge-to-memory length. An accepted write to code 2 or 3 starts a transfer of length+1 bytes, and `busy` reads 1 from the next clock edge on.
- R2: While `busy` is 1, every register write is ignored. This covers the address registers, and a length write does not start a second transfer.
- R3: When main-memory address + length + 1 is greater than `MM_BYTES`, no byte is written anywhere.
- R4: Cartridge addresses 0x08000000 through 0x08010000 inclusive select the save memory. The save byte offset is the cartridge address minus 0x08000000, taken modulo `SAVE_BYTES`. Both directions are supported.
- R5: Cartridge addresses 0x10000000 through 0x1FBFFFFF inclusive select the ROM, at offset cartridge address minus 0x10000000. The ROM is copied only in the cartridge-to-memory direction. A memory-to-cartridge request to this range moves nothing.
- R6: Byte i of a transfer reads source byte (source base + i) XOR 3 and writes destination byte (memory base + i) XOR 3.
- R7: In a ROM copy, destination bytes whose unswizzled ROM offset (offset + i) is at or past `ROM_BYTES` are written with 0.
- R8: A cartridge address outside both ranges completes with no byte written.
- R9: Every transfer ends with `busy` at 0 and `irq` at 1, whether or not any data moved.
- R10: `irq` stays at 1 until a cycle with `irq_ack` high clears it.
- R11: After the first ROM copy since reset that moves data, the engine writes `MM_BYTES` as a 32-bit little-endian word into main memory, with byte k at patch base + k. The patch base is 0x3F0 when `boot_code` equals `ALT_BOOT_CODE` and 0x318 otherwise. Later ROM copies skip the patch.
- R12: Reset leaves `busy` and `irq` at 0, and no memory is written while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (see R1) |
| reg_wdata | input | 32 | Register write data |
| irq_ack | input | 1 | Clears the interrupt flag |
| boot_code | input | BOOT_CODE_W | Boot variant code that selects the patch location |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Transfer-complete interrupt flag |
| mm_addr | output | $clog2(MM_BYTES) | Main-memory byte address |
| mm_we | output | 1 | Main-memory write enable |
| mm_wdata | output | 8 | Main-memory write byte |
| mm_rdata | input | 8 | Main-memory read byte, one cycle after address |
| rom_addr | output | $clog2(ROM_BYTES) | ROM byte address |
| rom_rdata | input | 8 | ROM read byte, one cycle after address |
| sv_addr | output | $clog2(SAVE_BYTES) | Save-memory byte address |
| sv_we | output | 1 | Save-memory write enable |
| sv_wdata | output | 8 | Save-memory write byte |
| sv_rdata | input | 8 | Save-memory read byte, one cycle after address |

## Verification
The assertions check the following on every cycle:
- Register writes are ignored while busy.
- A completion always clears busy and raises the interrupt.
- The interrupt falls only after an acknowledge.
- Nothing is written while idle.
- Save memory is written only in the memory-to-save direction.
- Data writes stay inside main memory.
- The boot patch runs only once.

The bench covers what a property cannot see. It compares the full main-memory and save-memory images against a reference model. That comparison shows the lane reversal, the zero padding past the ROM end, the window edges, and the choice of patch location after a second reset.

// File: rtl/cdma_pkg.sv
// Shared constants and types for the cartridge DMA engine.
// Assumes 32-bit cartridge and main-memory register values.
package cdma_pkg;
    localparam logic [31:0] SAVE_LO   = 32'h0800_0000;
    localparam logic [31:0] SAVE_HI   = 32'h0801_0000;
    localparam logic [31:0] ROM_LO    = 32'h1000_0000;
    localparam logic [31:0] ROM_HI    = 32'h1FBF_FFFF;
    localparam logic [31:0] PATCH_STD = 32'h0000_0318;
    localparam logic [31:0] PATCH_ALT = 32'h0000_03F0;

    localparam logic [1:0] SEL_DRAM    = 2'd0;
    localparam logic [1:0] SEL_CART    = 2'd1;
    localparam logic [1:0] SEL_LEN_OUT = 2'd2;
    localparam logic [1:0] SEL_LEN_IN  = 2'd3;

    typedef enum logic [1:0] {
        XK_NONE,
        XK_MEM2SAVE,
        XK_SAVE2MEM,
        XK_ROM2MEM
    } xfer_kind_e;

    typedef enum logic [2:0] {
        MS_IDLE,
        MS_READ,
        MS_WRITE,
        MS_PATCH,
        MS_DONE
    } mover_state_e;
endpackage

// File: rtl/cdma_regs.sv
// Register file, start logic, busy and interrupt flags.
// Assumes 'done' is a one-cycle pulse from the mover. Every write is
// dropped while busy is high.
module cdma_regs
    import cdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    input  logic        irq_ack,
    input  logic        done,
    output logic [31:0] dram_q,
    output logic [31:0] cart_q,
    output logic [31:0] len_q,
    output logic        to_cart_q,
    output logic        start_q,
    output logic        busy,
    output logic        irq
);
    logic accept;
    assign accept = reg_we && !busy;

    // Capture register writes, issue the start pulse, track busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dram_q    <= '0;
            cart_q    <= '0;
            len_q     <= '0;
            to_cart_q <= 1'b0;
            start_q   <= 1'b0;
            busy      <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (accept) begin
                case (reg_sel)
                    SEL_DRAM: dram_q <= reg_wdata;
                    SEL_CART: cart_q <= reg_wdata;
                    default: begin
                        len_q     <= reg_wdata;
                        to_cart_q <= (reg_sel == SEL_LEN_OUT);
                        start_q   <= 1'b1;
                        busy      <= 1'b1;
                    end
                endcase
            end
            if (done) busy <= 1'b0;
        end
    end

    // Interrupt flag: set on completion, cleared only by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (done)    irq <= 1'b1;
        else if (irq_ack) irq <= 1'b0;
    end

    // R2
    ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && reg_we |=> $stable(dram_q) && $stable(cart_q) && !start_q);
    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> busy);
    // R9
    done_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy && irq);
    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(irq_ack));
endmodule

// File: rtl/cdma_decode.sv
// Combinational target decode from the latched registers: main-memory
// bound check, window match, source offset, byte count and the number of
// bytes that exist in ROM.
// Assumes the ROM and save windows do not overlap.
module cdma_decode
    import cdma_pkg::*;
#(
    parameter int MM_BYTES  = 2048,
    parameter int ROM_BYTES = 512
) (
    input  logic [31:0] dram,
    input  logic [31:0] cart,
    input  logic [31:0] len,
    input  logic        to_cart,
    output xfer_kind_e  kind,
    output logic [31:0] cnt,
    output logic [31:0] src_off,
    output logic [31:0] avail
);
    localparam logic [32:0] MM_LIMIT = 33'(MM_BYTES);
    localparam logic [31:0] ROM_SIZE = 32'(ROM_BYTES);

    logic [32:0] end_addr;
    logic        fits, save_hit, rom_hit;
    logic [31:0] rom_off, room;

    assign end_addr = {1'b0, dram} + {1'b0, len} + 33'd1;
    assign fits     = (end_addr <= MM_LIMIT);
    assign save_hit = (cart >= SAVE_LO) && (cart <= SAVE_HI);
    assign rom_hit  = (cart >= ROM_LO) && (cart <= ROM_HI);
    assign rom_off  = cart - ROM_LO;
    assign room     = (rom_off >= ROM_SIZE) ? 32'd0 : (ROM_SIZE - rom_off);
    assign cnt      = len + 32'd1;

    // Pick the transfer kind and source parameters.
    always_comb begin
        kind    = XK_NONE;
        src_off = '0;
        avail   = '0;
        if (fits) begin
            if (save_hit) begin
                kind    = to_cart ? XK_MEM2SAVE : XK_SAVE2MEM;
                src_off = cart - SAVE_LO;
                avail   = cnt;
            end else if (rom_hit && !to_cart) begin
                kind    = XK_ROM2MEM;
                src_off = rom_off;
                avail   = (cnt < room) ? cnt : room;
            end
        end
    end
endmodule

// File: rtl/cdma_mover.sv
// Byte mover. Each byte takes a read cycle then a write cycle through
// synchronous one-cycle-latency memory ports. A boot patch phase follows
// the first ROM copy after reset.
// Assumes MM_BYTES >= 0x3F4 and all memory sizes are multiples of 4.
module cdma_mover
    import cdma_pkg::*;
#(
    parameter int MM_BYTES      = 2048,
    parameter int ROM_BYTES     = 512,
    parameter int SAVE_BYTES    = 256,
    parameter int BOOT_CODE_W   = 3,
    parameter int ALT_BOOT_CODE = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  xfer_kind_e                       kind,
    input  logic [31:0]                      dram,
    input  logic [31:0]                      src_off,
    input  logic [31:0]                      cnt,
    input  logic [31:0]                      avail,
    input  logic [BOOT_CODE_W-1:0]           boot_code,
    output logic                             done,
    output logic [$clog2(MM_BYTES)-1:0]      mm_addr,
    output logic                             mm_we,
    output logic [7:0]                       mm_wdata,
    input  logic [7:0]                       mm_rdata,
    output logic [$clog2(ROM_BYTES)-1:0]     rom_addr,
    input  logic [7:0]                       rom_rdata,
    output logic [$clog2(SAVE_BYTES)-1:0]    sv_addr,
    output logic                             sv_we,
    output logic [7:0]                       sv_wdata,
    input  logic [7:0]                       sv_rdata
);
    localparam int          MM_AW   = $clog2(MM_BYTES);
    localparam int          ROM_AW  = $clog2(ROM_BYTES);
    localparam int          SV_AW   = $clog2(SAVE_BYTES);
    localparam logic [31:0] MM_WORD = 32'(MM_BYTES);

    mover_state_e state;
    xfer_kind_e   kind_q;
    logic [31:0]  dbase_q, sbase_q, last_q, avail_q, idx_q;
    logic [1:0]   pk_q;
    logic         booted_q;
    logic [31:0]  patch_base;

    assign patch_base = (boot_code == BOOT_CODE_W'(ALT_BOOT_CODE)) ? PATCH_ALT : PATCH_STD;
    assign done       = (state == MS_DONE);

    // Drive the memory ports from the current state and byte index.
    always_comb begin
        mm_addr  = MM_AW'((dbase_q + idx_q) ^ 32'd3);
        rom_addr = ROM_AW'((sbase_q + idx_q) ^ 32'd3);
        sv_addr  = SV_AW'((sbase_q + idx_q) ^ 32'd3);
        mm_we    = 1'b0;
        mm_wdata = 8'd0;
        sv_we    = 1'b0;
        sv_wdata = mm_rdata;
        case (state)
            MS_WRITE: begin
                case (kind_q)
                    XK_MEM2SAVE: sv_we = 1'b1;
                    XK_SAVE2MEM: begin
                        mm_we    = 1'b1;
                        mm_wdata = sv_rdata;
                    end
                    XK_ROM2MEM: begin
                        mm_we    = 1'b1;
                        mm_wdata = (idx_q < avail_q) ? rom_rdata : 8'd0;
                    end
                    default: ;
                endcase
            end
            MS_PATCH: begin
                mm_addr  = MM_AW'(patch_base + {30'd0, pk_q});
                mm_we    = 1'b1;
                mm_wdata = MM_WORD[{pk_q, 3'b000} +: 8];
            end
            default: ;
        endcase
    end

    // Sequence the read/write phases, the patch phase and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= MS_IDLE;
            kind_q   <= XK_NONE;
            dbase_q  <= '0;
            sbase_q  <= '0;
            last_q   <= '0;
            avail_q  <= '0;
            idx_q    <= '0;
            pk_q     <= '0;
            booted_q <= 1'b0;
        end else begin
            case (state)
                MS_IDLE: if (start) begin
                    kind_q  <= kind;
                    dbase_q <= dram;
                    sbase_q <= src_off;
                    last_q  <= cnt - 32'd1;
                    avail_q <= avail;
                    idx_q   <= '0;
                    pk_q    <= '0;
                    state   <= (kind == XK_NONE) ? MS_DONE : MS_READ;
                end
                MS_READ: state <= MS_WRITE;
                MS_WRITE: begin
                    if (idx_q == last_q) begin
                        state <= (kind_q == XK_ROM2MEM && !booted_q) ? MS_PATCH : MS_DONE;
                    end else begin
                        idx_q <= idx_q + 32'd1;
                        state <= MS_READ;
                    end
                end
                MS_PATCH: begin
                    pk_q <= pk_q + 2'd1;
                    if (pk_q == 2'd3) begin
                        booted_q <= 1'b1;
                        state    <= MS_DONE;
                    end
                end
                default: state <= MS_IDLE;
            endcase
        end
    end

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == MS_IDLE |-> !mm_we && !sv_we);
    // R11
    patch_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == MS_PATCH |-> !booted_q);
    // R4
    save_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sv_we |-> kind_q == XK_MEM2SAVE);
    // R3
    mm_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == MS_WRITE |-> (dbase_q + idx_q) < 32'(MM_BYTES));
endmodule

// File: rtl/cart_dma.sv
// Top of the cartridge DMA engine: registers, decode and mover.
// Assumes byte-wide synchronous memories that return read data one
// cycle after the address.
module cart_dma
    import cdma_pkg::*;
#(
    parameter int MM_BYTES      = 2048,
    parameter int ROM_BYTES     = 512,
    parameter int SAVE_BYTES    = 256,
    parameter int BOOT_CODE_W   = 3,
    parameter int ALT_BOOT_CODE = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_we,
    input  logic [1:0]                    reg_sel,
    input  logic [31:0]                   reg_wdata,
    input  logic                          irq_ack,
    input  logic [BOOT_CODE_W-1:0]        boot_code,
    output logic                          busy,
    output logic                          irq,
    output logic [$clog2(MM_BYTES)-1:0]   mm_addr,
    output logic                          mm_we,
    output logic [7:0]                    mm_wdata,
    input  logic [7:0]                    mm_rdata,
    output logic [$clog2(ROM_BYTES)-1:0]  rom_addr,
    input  logic [7:0]                    rom_rdata,
    output logic [$clog2(SAVE_BYTES)-1:0] sv_addr,
    output logic                          sv_we,
    output logic [7:0]                    sv_wdata,
    input  logic [7:0]                    sv_rdata
);
    logic [31:0] dram_q, cart_q, len_q, cnt, src_off, avail;
    logic        to_cart_q, start_q, done;
    xfer_kind_e  kind;

    cdma_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .irq_ack(irq_ack), .done(done),
        .dram_q(dram_q), .cart_q(cart_q), .len_q(len_q),
        .to_cart_q(to_cart_q), .start_q(start_q), .busy(busy), .irq(irq)
    );

    cdma_decode #(.MM_BYTES(MM_BYTES), .ROM_BYTES(ROM_BYTES)) u_decode (
        .dram(dram_q), .cart(cart_q), .len(len_q), .to_cart(to_cart_q),
        .kind(kind), .cnt(cnt), .src_off(src_off), .avail(avail)
    );

    cdma_mover #(
        .MM_BYTES(MM_BYTES), .ROM_BYTES(ROM_BYTES), .SAVE_BYTES(SAVE_BYTES),
        .BOOT_CODE_W(BOOT_CODE_W), .ALT_BOOT_CODE(ALT_BOOT_CODE)
    ) u_mover (
        .clk(clk), .rst_n(rst_n), .start(start_q), .kind(kind),
        .dram(dram_q), .src_off(src_off), .cnt(cnt), .avail(avail),
        .boot_code(boot_code), .done(done),
        .mm_addr(mm_addr), .mm_we(mm_we), .mm_wdata(mm_wdata), .mm_rdata(mm_rdata),
        .rom_addr(rom_addr), .rom_rdata(rom_rdata),
        .sv_addr(sv_addr), .sv_we(sv_we), .sv_wdata(sv_wdata), .sv_rdata(sv_rdata)
    );
endmodule

// File: tb/cart_dma_bench.sv
module cart_dma_bench;
    localparam int MMB  = 2048;
    localparam int ROMB = 512;
    localparam int SVB  = 256;
    localparam int NV   = 10;

    // Vector table: direction (1 = memory to cartridge), memory address,
    // cartridge address, length register value.
    localparam bit          V_OUT  [NV] = '{0, 1, 0, 0, 0, 0, 0, 1, 0, 0};
    localparam logic [31:0] V_DRAM [NV] = '{32'h400, 32'h400, 32'h600, 32'h700, MMB-8,
                                            MMB-8, 32'h100, 32'h100, 32'h100, 32'h120};
    localparam logic [31:0] V_CART [NV] = '{32'h1000_0010, 32'h0800_0020, 32'h0800_0020,
                                            32'h1000_0000 + ROMB - 16, 32'h1000_0000,
                                            32'h1000_0000, 32'h0500_0000, 32'h1000_0000,
                                            32'h0801_0000, 32'h0801_0004};
    localparam logic [31:0] V_LEN  [NV] = '{63, 31, 31, 39, 8, 7, 15, 15, 3, 3};
    // v0 R5 R11, v1 R4 out, v2 R4 in, v3 R7, v4 R3, v5 R3 exact fit,
    // v6 R8, v7 R5 wrong direction, v8 R4 top edge, v9 R8 just past.

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0, reg_we = 1'b0, irq_ack = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  boot_code = 3'd0;
    logic        busy, irq, mm_we, sv_we;
    logic [10:0] mm_addr;
    logic [8:0]  rom_addr;
    logic [7:0]  sv_addr, mm_wdata, sv_wdata;
    logic [7:0]  mm_rdata, rom_rdata, sv_rdata;

    cart_dma u_cart_dma (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .irq_ack(irq_ack), .boot_code(boot_code),
        .busy(busy), .irq(irq),
        .mm_addr(mm_addr), .mm_we(mm_we), .mm_wdata(mm_wdata), .mm_rdata(mm_rdata),
        .rom_addr(rom_addr), .rom_rdata(rom_rdata),
        .sv_addr(sv_addr), .sv_we(sv_we), .sv_wdata(sv_wdata), .sv_rdata(sv_rdata)
    );

    logic [7:0] mm [MMB];
    logic [7:0] sv [SVB];
    logic [7:0] exp_mm [MMB];
    logic [7:0] exp_sv [SVB];
    bit ref_booted = 0;

    function automatic logic [7:0] rom_val(input longint a);
        return 8'((a * 13 + 7) & 255);
    endfunction

    always @(posedge clk) begin
        if (mm_we) mm[mm_addr] <= mm_wdata;
        mm_rdata <= mm[mm_addr];
        if (sv_we) sv[sv_addr] <= sv_wdata;
        sv_rdata <= sv[sv_addr];
        rom_rdata <= rom_val(longint'(rom_addr));
    end

    int total = 0, bad = 0, cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(!busy, "R9 busy never cleared", 32'(busy), 0);
    endtask

    // Reference model of one transfer, built from the requirements.
    task automatic ref_apply(input bit out, input logic [31:0] dram, input logic [31:0] cart,
                             input logic [31:0] len);
        longint cnt  = longint'(len) + 1;
        longint base = longint'(dram);
        longint off;
        if (base + cnt > MMB) return;                        // R3
        if (cart >= 32'h0800_0000 && cart <= 32'h0801_0000) begin  // R4
            off = longint'(cart) - 64'h0800_0000;
            for (longint i = 0; i < cnt; i++) begin
                if (out) exp_sv[((off + i) ^ 3) % SVB] = exp_mm[(base + i) ^ 3];
                else     exp_mm[(base + i) ^ 3] = exp_sv[((off + i) ^ 3) % SVB];
            end
        end else if (cart >= 32'h1000_0000 && cart <= 32'h1FBF_FFFF && !out) begin  // R5
            off = longint'(cart) - 64'h1000_0000;
            for (longint i = 0; i < cnt; i++)                // R6 R7
                exp_mm[(base + i) ^ 3] = (off + i < ROMB) ? rom_val((off + i) ^ 3) : 8'd0;
            if (!ref_booted) begin                           // R11
                for (int k = 0; k < 4; k++)
                    exp_mm[((boot_code == 3'd5) ? 32'h3F0 : 32'h318) + k] = 8'(MMB >> (8 * k));
                ref_booted = 1;
            end
        end
    endtask

    task automatic check_mem(input string req);
        int diff = 0, first = -1;
        for (int i = 0; i < MMB; i++)
            if (mm[i] !== exp_mm[i]) begin diff++; if (first < 0) first = i; end
        chk(diff == 0, {req, " main memory"}, first < 0 ? 0 : 32'(mm[first]),
            first < 0 ? 0 : 32'(exp_mm[first]));
        diff = 0; first = -1;
        for (int i = 0; i < SVB; i++)
            if (sv[i] !== exp_sv[i]) begin diff++; if (first < 0) first = i; end
        chk(diff == 0, {req, " save memory"}, first < 0 ? 0 : 32'(sv[first]),
            first < 0 ? 0 : 32'(exp_sv[first]));
    endtask

    task automatic run(input bit out, input logic [31:0] dram, input logic [31:0] cart,
                       input logic [31:0] len);
        wr_reg(2'd0, dram);
        wr_reg(2'd1, cart);
        wr_reg(out ? 2'd2 : 2'd3, len);
        chk(busy === 1'b1, "R1 busy after start", 32'(busy), 1);
        wait_idle();
        ref_apply(out, dram, cart, len);
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        chk(irq === 1'b0, "R10 irq cleared by ack", 32'(irq), 0);
    endtask

    initial begin
        for (int i = 0; i < MMB; i++) begin mm[i] = 8'(i * 5 + 1); exp_mm[i] = 8'(i * 5 + 1); end
        for (int i = 0; i < SVB; i++) begin sv[i] = 8'(i ^ 8'hA5); exp_sv[i] = 8'(i ^ 8'hA5); end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(busy === 1'b0, "R12 busy after reset", 32'(busy), 0);
        chk(irq === 1'b0, "R12 irq after reset", 32'(irq), 0);
        check_mem("R12 idle");

        for (int v = 0; v < NV; v++) begin
            run(V_OUT[v], V_DRAM[v], V_CART[v], V_LEN[v]);
            check_mem($sformatf("R6 vector %0d", v));
            chk(!busy, $sformatf("R9 busy low vector %0d", v), 32'(busy), 0);
            chk(irq === 1'b1, $sformatf("R9 irq set vector %0d", v), 32'(irq), 1);
            ack();
        end

        // R11 standard patch location holds the memory size
        chk({mm[32'h31B], mm[32'h31A], mm[32'h319], mm[32'h318]} == 32'(MMB),
            "R11 patch at 0x318", {mm[32'h31B], mm[32'h31A], mm[32'h319], mm[32'h318]}, MMB);

        // R2 writes while busy are dropped
        wr_reg(2'd0, 32'h200);
        wr_reg(2'd1, 32'h1000_0040);
        wr_reg(2'd3, 32'd31);
        wr_reg(2'd1, 32'h0800_0000);
        wr_reg(2'd3, 32'd5);
        wait_idle();
        ref_apply(0, 32'h200, 32'h1000_0040, 32'd31);
        repeat (6) @(negedge clk);
        chk(!busy, "R2 no second start", 32'(busy), 0);
        // R10 irq holds without ack
        chk(irq === 1'b1, "R10 irq held", 32'(irq), 1);
        check_mem("R2 single transfer");
        wr_reg(2'd3, 32'd7);
        wait_idle();
        ref_apply(0, 32'h200, 32'h1000_0040, 32'd7);
        check_mem("R2 cart register kept");

        // R11 alternate variant after a fresh reset; R12 reset clears irq
        boot_code = 3'd5;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(irq === 1'b0, "R12 irq after second reset", 32'(irq), 0);
        ref_booted = 0;
        run(0, 32'h000, 32'h1000_0000, 32'd15);
        check_mem("R11 alternate patch");
        chk({mm[32'h3F3], mm[32'h3F2], mm[32'h3F1], mm[32'h3F0]} == 32'(MMB),
            "R11 patch at 0x3F0", {mm[32'h3F3], mm[32'h3F2], mm[32'h3F1], mm[32'h3F0]}, MMB);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule